// File: doc/BRIEF.md
# Sector Bit-Error Correction Applier

This block sits behind a BCH decoder that has already located the bit errors in a 512-byte flash sector. The sector is held in a local byte RAM. The host fills that RAM through a simple byte port, then presents a decoder status report and pulses `start`. The block checks the report's flags first. It then walks through the listed error positions in order and inverts each usable bit with a read-modify-write of its byte. At the end it raises a one-cycle `done` pulse, together with the number of bits it inverted or a failure flag. The host then reads the corrected sector back through the same byte port.

The report has two parts. The first is a status word with the flags and the error count. The second is a group of packed words, each carrying two 13-bit bit positions. A position that points outside the sector is skipped and costs one cycle. A usable position costs two cycles: one to read the byte and one to write it back.

Top module: `bchfix_top`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `fixed_cnt` and `fail` are all 0.
- R2: `start` is accepted only while `busy` is 0. The report is captured on the accepting edge. A `start` seen while busy is ignored and leaves the result unchanged.
- R3: Status word layout: bit 0 is the uncorrectable flag, bit 1 is the errors-found flag, and bits 7:4 are the error count. Position slot i sits in packed word i/2 (`rpt_slots[32*(i/2) +: 32]`). Even slots use bits 12:0 and odd slots use bits 28:16, so the lower field comes first.
- R4: If errors-found is 0, the result is `fixed_cnt`=0 and `fail`=0, and the sector is unchanged. The uncorrectable flag and the count are not looked at.
- R5: If errors-found is 1 and either the uncorrectable flag is 1 or the count exceeds 8, the result is `fail`=1 and `fixed_cnt`=0, and no bit is inverted.
- R6: Only the first `count` slots are visited, in slot order. A position of 4096 (512×8) or more is skipped.
- R7: Position p inverts bit p mod 8 of byte p/8, where bit 0 is the least significant bit.
- R8: `fixed_cnt` equals the number of inversions performed, which is at most 8. A position listed twice is inverted twice and counts 2.
- R9: `busy` is 1 from the accepting edge until `done`. `done` is a one-cycle pulse that comes L rising edges after the accepting edge:
  - L = 1 when the report is rejected or reports no errors;
  - otherwise L = 2 + 2·(applied slots) + (skipped slots).
- R10: While idle, `host_we` writes `host_wdata` into byte `host_addr`, and `host_rdata` shows the byte at `host_addr` one cycle after the address. A host write made in the same cycle as an accepted `start` lands before the corrections. Host writes made while busy are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin processing the presented report |
| rpt_status | input | 32 | Status word: flags and error count |
| rpt_slots | input | 128 | Packed error positions, two per 32-bit word |
| host_we | input | 1 | Host byte write enable (honoured only while idle) |
| host_addr | input | 9 | Host byte address into the sector |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Byte read at the previous cycle's address |
| busy | output | 1 | Report being processed |
| done | output | 1 | One-cycle completion pulse |
| fixed_cnt | output | 4 | Bits inverted by the last report |
| fail | output | 1 | Last report was uncorrectable |

## Verification
A host write and an accepted `start` can fall in the same cycle, and the corrections must then act on the freshly written byte. The bench drives a host write to a target byte together with the start pulse and judges the read-back byte against the written value with the flip applied. Two further pokes are made while the block is busy: a second `start` carrying a different report, and a write to a neighbouring byte. The bench expects neither to change the result or that byte. A behavioural model predicts `busy`, `done`, the result and every idle read cycle by cycle, so any shift in latency or ownership of the RAM port shows up at once.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;
  localparam int WORD_W      = 32;
  localparam int F_UNCORR    = 0;
  localparam int F_FOUND     = 1;
  localparam int F_CNT_LO    = 4;
  localparam int CNT_W       = 4;
  localparam int SLOT_STRIDE = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SCAN,
    ST_MODIFY
  } fix_state_t;
endpackage

// File: rtl/bchfix_unpack.sv
module bchfix_unpack
  import bchfix_pkg::*;
#(
  parameter int NPOS  = 8,
  parameter int POS_W = 13
) (
  input  logic [WORD_W-1:0]               hdr,
  input  logic [((NPOS+1)/2)*WORD_W-1:0]  slots,
  output logic                            found,
  output logic                            uncorr,
  output logic [CNT_W-1:0]                cnt,
  output logic [NPOS*POS_W-1:0]           pos_flat
);
  assign found  = hdr[F_FOUND];
  assign uncorr = hdr[F_UNCORR];
  assign cnt    = hdr[F_CNT_LO +: CNT_W];

  // slot i: word i/2, lower field for even i, upper field for odd i
  for (genvar i = 0; i < NPOS; i++) begin : g_slot
    assign pos_flat[i*POS_W +: POS_W] =
      slots[(i/2)*WORD_W + (i%2)*SLOT_STRIDE +: POS_W];
  end

  logic unused_bits;
  assign unused_bits = ^{hdr, slots};
endmodule

// File: rtl/bchfix_ram.sv
module bchfix_ram #(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  // read-first single port, block RAM style
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/bchfix_seq.sv
module bchfix_seq
  import bchfix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int NPOS         = 8,
  parameter int POS_W        = 13,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES),
  parameter int FIX_W        = $clog2(NPOS+1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  found,
  input  logic                  uncorr,
  input  logic [CNT_W-1:0]      cnt,
  input  logic [NPOS*POS_W-1:0] pos_flat,
  input  logic [7:0]            ram_rdata,
  output logic [ADDR_W-1:0]     eng_addr,
  output logic                  eng_we,
  output logic [7:0]            eng_wdata,
  output logic                  busy,
  output logic                  done,
  output logic [FIX_W-1:0]      fixed_cnt,
  output logic                  fail
);
  localparam logic [31:0]      BIT_LIMIT = 32'(SECTOR_BYTES * 8);
  localparam logic [CNT_W-1:0] NPOS_C    = CNT_W'(NPOS);

  fix_state_t        state;
  logic [CNT_W-1:0]  idx_q;
  logic [FIX_W-1:0]  flips_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        bit_q;
  logic              done_q, fail_q;
  logic [FIX_W-1:0]  fixed_q;
  logic [POS_W-1:0]  cur_pos;
  logic              pos_ok;

  always_comb begin
    cur_pos = '0;
    for (int i = 0; i < NPOS; i++)
      if (idx_q == CNT_W'(i)) cur_pos = pos_flat[i*POS_W +: POS_W];
  end

  assign pos_ok = (32'(cur_pos) < BIT_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx_q   <= '0;
      flips_q <= '0;
      addr_q  <= '0;
      bit_q   <= '0;
      done_q  <= 1'b0;
      fixed_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_CHECK;
            idx_q   <= '0;
            flips_q <= '0;
          end
        end
        ST_CHECK: begin
          if (!found) begin
            done_q  <= 1'b1;
            fixed_q <= '0;
            fail_q  <= 1'b0;
            state   <= ST_IDLE;
          end else if (uncorr || cnt > NPOS_C) begin
            done_q  <= 1'b1;
            fixed_q <= '0;
            fail_q  <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            state <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (idx_q == cnt) begin
            done_q  <= 1'b1;
            fixed_q <= flips_q;
            fail_q  <= 1'b0;
            state   <= ST_IDLE;
          end else if (pos_ok) begin
            addr_q <= cur_pos[ADDR_W+2:3];
            bit_q  <= cur_pos[2:0];
            state  <= ST_MODIFY;
          end else begin
            idx_q <= idx_q + CNT_W'(1);
          end
        end
        ST_MODIFY: begin
          flips_q <= flips_q + FIX_W'(1);
          idx_q   <= idx_q + CNT_W'(1);
          state   <= ST_SCAN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign eng_addr  = (state == ST_MODIFY) ? addr_q : cur_pos[ADDR_W+2:3];
  assign eng_we    = (state == ST_MODIFY);
  assign eng_wdata = ram_rdata ^ (8'(1) << bit_q);
  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign fixed_cnt = fixed_q;
  assign fail      = fail_q;

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R4
  nofound_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CHECK && !found) |=> (done_q && fixed_q == '0 && !fail_q));

  // R7
  write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> ($past(state) == ST_SCAN));
endmodule

// File: rtl/bchfix_top.sv
module bchfix_top
  import bchfix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int NPOS         = 8,
  parameter int POS_W        = 13
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 start,
  input  logic [31:0]                          rpt_status,
  input  logic [((NPOS+1)/2)*32-1:0]           rpt_slots,
  input  logic                                 host_we,
  input  logic [$clog2(SECTOR_BYTES)-1:0]      host_addr,
  input  logic [7:0]                           host_wdata,
  output logic [7:0]                           host_rdata,
  output logic                                 busy,
  output logic                                 done,
  output logic [$clog2(NPOS+1)-1:0]            fixed_cnt,
  output logic                                 fail
);
  localparam int ADDR_W = $clog2(SECTOR_BYTES);
  localparam int FIX_W  = $clog2(NPOS+1);
  localparam int SLOTS_W = ((NPOS+1)/2)*32;

  logic [31:0]          hdr_q;
  logic [SLOTS_W-1:0]   slots_q;
  logic                 found, uncorr;
  logic [CNT_W-1:0]     cnt;
  logic [NPOS*POS_W-1:0] pos_flat;
  logic [ADDR_W-1:0]    eng_addr, ram_addr;
  logic                 eng_we, ram_we;
  logic [7:0]           eng_wdata, ram_wdata, ram_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q   <= '0;
      slots_q <= '0;
    end else if (start && !busy) begin
      hdr_q   <= rpt_status;
      slots_q <= rpt_slots;
    end
  end

  bchfix_unpack #(.NPOS(NPOS), .POS_W(POS_W)) u_unpack (
    .hdr(hdr_q), .slots(slots_q),
    .found(found), .uncorr(uncorr), .cnt(cnt), .pos_flat(pos_flat)
  );

  bchfix_seq #(.SECTOR_BYTES(SECTOR_BYTES), .NPOS(NPOS), .POS_W(POS_W)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .found(found), .uncorr(uncorr), .cnt(cnt), .pos_flat(pos_flat),
    .ram_rdata(ram_rdata),
    .eng_addr(eng_addr), .eng_we(eng_we), .eng_wdata(eng_wdata),
    .busy(busy), .done(done), .fixed_cnt(fixed_cnt), .fail(fail)
  );

  // engine owns the RAM port while busy; host writes are dropped then
  assign ram_addr  = busy ? eng_addr  : host_addr;
  assign ram_we    = busy ? eng_we    : host_we;
  assign ram_wdata = busy ? eng_wdata : host_wdata;

  bchfix_ram #(.DEPTH(SECTOR_BYTES)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  assign host_rdata = ram_rdata;

  // R5
  fail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fail) |-> (fixed_cnt == '0));

  // R8
  fixed_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (32'(fixed_cnt) <= NPOS));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/tb_bchfix_top.sv
module tb_bchfix_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [31:0]  rpt_status = '0;
  logic [127:0] rpt_slots = '0;
  logic         host_we = 1'b0;
  logic [8:0]   host_addr = '0;
  logic [7:0]   host_wdata = '0;
  logic [7:0]   host_rdata;
  logic         busy, done, fail;
  logic [3:0]   fixed_cnt;

  always #10 clk = ~clk;

  bchfix_top dut (
    .clk(clk), .rst(rst), .start(start),
    .rpt_status(rpt_status), .rpt_slots(rpt_slots),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .busy(busy), .done(done),
    .fixed_cnt(fixed_cnt), .fail(fail)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  bit live = 0, chk_rd = 0, finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int init_b(input int i);
    return (i * 37 + 11) & 255;
  endfunction

  // ---------------- behavioural reference model ----------------
  int mdl_mem [512];
  int plan_q [$];
  int plan_fixed, plan_fail, left;
  bit exp_busy = 0, exp_done = 0, exp_fail = 0, rd_valid = 0;
  int exp_fixed = 0, exp_rd = 0;

  function automatic int slot_pos(input logic [127:0] s, input int i);
    return int'((s >> (32 * (i / 2) + 16 * (i % 2))) & 128'h1fff);
  endfunction

  task automatic plan_report();
    int cnt;
    int steps;
    cnt = int'(rpt_status[7:4]);
    plan_q.delete();
    plan_fixed = 0;
    plan_fail = 0;
    if (!rpt_status[1]) left = 1;
    else if (rpt_status[0] || cnt > 8) begin plan_fail = 1; left = 1; end
    else begin
      steps = 0;
      for (int i = 0; i < cnt; i++) begin
        int p;
        p = slot_pos(rpt_slots, i);
        if (p < 4096) begin plan_q.push_back(p); steps += 2; end
        else steps += 1;
      end
      plan_fixed = plan_q.size();
      left = 2 + steps;
    end
    exp_busy = 1;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      exp_busy = 0; exp_done = 0; exp_fixed = 0; exp_fail = 0; rd_valid = 0;
    end else begin
      rd_valid = !exp_busy && chk_rd;
      if (!exp_busy) exp_rd = mdl_mem[host_addr];
      exp_done = 0;
      if (exp_busy) begin
        left--;
        if (left == 0) begin
          exp_busy = 0;
          exp_done = 1;
          exp_fixed = plan_fixed;
          exp_fail = plan_fail;
          foreach (plan_q[k]) mdl_mem[plan_q[k] >> 3] ^= (1 << (plan_q[k] & 7));
          plan_q.delete();
        end
      end else begin
        if (host_we) mdl_mem[host_addr] = int'(host_wdata);
        if (start) plan_report();
      end
    end
  end

  always @(negedge clk) begin
    if (live && !rst && !finished) begin
      check("R9 busy", int'(busy), int'(exp_busy));
      check("R9 done", int'(done), int'(exp_done));
      check("R8 fixed_cnt", int'(fixed_cnt), exp_fixed);
      check("R5 fail", int'(fail), int'(exp_fail));
      if (rd_valid) check("R10 host_rdata", int'(host_rdata), exp_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] mkh(input bit f, input bit u, input int c);
    return {24'b0, 4'(c), 2'b0, f, u};
  endfunction

  function automatic logic [127:0] mks(input int p0, p1, p2, p3, p4, p5, p6, p7);
    return {3'b0, 13'(p7), 3'b0, 13'(p6), 3'b0, 13'(p5), 3'b0, 13'(p4),
            3'b0, 13'(p3), 3'b0, 13'(p2), 3'b0, 13'(p1), 3'b0, 13'(p0)};
  endfunction

  task automatic read_byte(input int a, output int v);
    @(negedge clk);
    host_addr = 9'(a);
    @(negedge clk);
    v = int'(host_rdata);
  endtask

  // pk: negedge index after start at which a one-cycle poke is made
  task automatic run(input logic [31:0] h, input logic [127:0] s,
                     input bit st_hw, input int st_a, input int st_d,
                     input int pk, input bit pk_start, input bit pk_hw,
                     input int pk_a, input int pk_d, output int edges);
    int k;
    @(negedge clk);
    rpt_status = h; rpt_slots = s; start = 1'b1;
    host_we = st_hw; host_addr = 9'(st_a); host_wdata = 8'(st_d);
    k = 0;
    do begin
      @(negedge clk);
      k++;
      start = 1'b0; host_we = 1'b0;
      if (k == pk) begin
        start = pk_start;
        if (pk_start) rpt_status = mkh(0, 0, 0);
        host_we = pk_hw; host_addr = 9'(pk_a); host_wdata = 8'(pk_d);
      end
    end while (!done && k < 1000);
    start = 1'b0; host_we = 1'b0;
    edges = k - 1;
  endtask

  // ---------------- test sequence ----------------
  initial begin
    int v, e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    live = 1;
    @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 fixed_cnt", int'(fixed_cnt), 0);
    check("R1 fail", int'(fail), 0);

    for (int i = 0; i < 512; i++) begin
      host_we = 1'b1; host_addr = 9'(i); host_wdata = 8'(init_b(i));
      @(negedge clk);
    end
    host_we = 1'b0;
    chk_rd = 1;
    read_byte(5, v);
    check("R10 load/readback", v, init_b(5));

    // no errors found, other fields set: ignored
    run(mkh(0, 1, 2), mks(0, 8, 0, 0, 0, 0, 0, 0), 0, 0, 0, 0, 0, 0, 0, 0, e);
    check("R4 fixed_cnt", int'(fixed_cnt), 0);
    check("R4 fail", int'(fail), 0);
    check("R9 early latency", e, 1);
    read_byte(0, v); check("R4 byte0 untouched", v, init_b(0));
    read_byte(1, v); check("R4 byte1 untouched", v, init_b(1));

    // uncorrectable
    run(mkh(1, 1, 2), mks(0, 8, 0, 0, 0, 0, 0, 0), 0, 0, 0, 0, 0, 0, 0, 0, e);
    check("R5 fail uncorr", int'(fail), 1);
    check("R5 fixed_cnt uncorr", int'(fixed_cnt), 0);
    read_byte(0, v); check("R5 byte0 untouched", v, init_b(0));

    // count above 8
    run(mkh(1, 0, 9), mks(0, 8, 16, 24, 32, 40, 48, 56), 0, 0, 0, 0, 0, 0, 0, 0, e);
    check("R5 fail count9", int'(fail), 1);
    read_byte(1, v); check("R5 byte1 untouched", v, init_b(1));

    // three usable positions including both sector ends
    run(mkh(1, 0, 3), mks(0, 4095, 1234, 0, 0, 0, 0, 0), 0, 0, 0, 0, 0, 0, 0, 0, e);
    check("R8 fixed 3", int'(fixed_cnt), 3);
    check("R9 latency 3 applied", e, 8);
    read_byte(0, v);   check("R7 byte0 bit0", v, init_b(0) ^ 1);
    read_byte(511, v); check("R7 byte511 bit7", v, init_b(511) ^ 128);
    read_byte(154, v); check("R3 slot2 byte154 bit2", v, init_b(154) ^ 4);

    // eight slots: out-of-range skips, duplicate, upper fields
    run(mkh(1, 0, 8), mks(100, 4096, 100, 8191, 7, 15, 4100, 3000),
        0, 0, 0, 0, 0, 0, 0, 0, e);
    check("R6 skip out-of-range fixed", int'(fixed_cnt), 5);
    check("R9 latency mixed", e, 15);
    read_byte(12, v);  check("R8 duplicate cancels", v, init_b(12));
    read_byte(375, v); check("R3 slot7 upper field", v, init_b(375) ^ 1);
    read_byte(1, v);   check("R7 byte1 bit7", v, init_b(1) ^ 128);

    // only first count slots used
    run(mkh(1, 0, 2), mks(200, 208, 216, 224, 0, 0, 0, 0), 0, 0, 0, 0, 0, 0, 0, 0, e);
    check("R6 count limits", int'(fixed_cnt), 2);
    read_byte(27, v); check("R6 slot past count unused", v, init_b(27));
    read_byte(26, v); check("R6 slot1 applied", v, init_b(26) ^ 1);

    // zero count
    run(mkh(1, 0, 0), mks(0, 0, 0, 0, 0, 0, 0, 0), 0, 0, 0, 0, 0, 0, 0, 0, e);
    check("R6 zero count fixed", int'(fixed_cnt), 0);
    check("R9 zero count latency", e, 2);

    // host write with start, then pokes while busy
    run(mkh(1, 0, 1), mks(323, 0, 0, 0, 0, 0, 0, 0), 1, 40, 8'h5A,
        2, 0, 1, 41, 8'hFF, e);
    check("R10 same-cycle write first", int'(fixed_cnt), 1);
    read_byte(40, v); check("R10 byte40 written then flipped", v, 8'h52);
    read_byte(41, v); check("R10 busy write dropped", v, init_b(41));
    run(mkh(1, 0, 1), mks(8, 0, 0, 0, 0, 0, 0, 0), 0, 0, 0,
        3, 1, 0, 0, 0, e);
    check("R2 start while busy ignored", int'(fixed_cnt), 1);
    @(negedge clk);
    check("R2 no restart", int'(busy), 0);

    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      host_addr = 9'(i);
    end
    repeat (2) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule